// File: doc/BRIEF.md
# Per-Port Byte Rate Limiter

This block polices the byte rate of one switch port. It keeps a byte budget for each traffic direction, receive and transmit, and for each of two priority classes. Each budget counts the bytes reported by a packet-byte strobe during the current one-second accounting window. A periodic tick marks the window boundary and restarts every count.

A budget whose count has gone past its programmed limit raises a block flag. The port logic then holds back further packets of that direction and class until the next tick. A packet that is already in progress when the limit is crossed completes, and the block takes effect at the next packet boundary. On receive, the block can also request flow control before the limit is reached, so that the link partner can slow down before packets are lost. The warning margin depends on the programmed rate: 8192 bytes for limits of at least 16000 bytes per second (128 Kbps), and 2048 bytes below that. With priority enabled, each class is counted against its own limit. With priority disabled, all traffic uses the low-class budget.

Top module: `port_rate_limiter`

## Requirements
- R1: Each budget adds the byte count of every strobe routed to it. On a cycle with `win_tick` high, the budget restarts from that cycle's strobe bytes, or from zero if there is no strobe.
- R2: A budget count saturates at 2^CW-1 and never wraps to a small value.
- R3: A receive budget whose count is strictly greater than its non-zero limit sets its bit of `rx_block`. The bit is set at a packet boundary and stays set until the next `win_tick`.
- R4: A block bit never rises while a packet of its budget is in progress. A packet is in progress from a strobe with `*_last` low until a strobe with `*_last` high. The bit rises on the cycle after the strobe carrying `*_last`.
- R5: Transmit budgets follow the rules of R3 and R4 on `tx_block`, using the transmit limits.
- R6: A limit of zero means unlimited. That budget never blocks and never requests flow control.
- R7: For a receive limit of 16000 or more, `rx_fc` is requested once count + 8192 >= limit.
- R8: For a receive limit from 1 to 15999, `rx_fc` is requested once count + 2048 >= limit.
- R9: With `fc_en` low, `rx_fc` is low on the following cycle and stays low.
- R10: Once raised, `rx_fc` stays high until `win_tick` clears it. It stays high through the tick only if the near-limit condition holds again for the new window.
- R11: With `prio_en` high, a strobe with `*_hi` high goes to the high-class budget. That budget is checked against the `*_lim_hi` limit and is reported on bit 1 of the block vector. Bit 0 reports the low class. With `prio_en` low, all strobes use the low-class budget and both bits show its state.
- R12: A `win_tick` cycle with no strobe in that direction clears all block bits of that direction on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_tick | input | 1 | One-second window boundary pulse |
| prio_en | input | 1 | Enables separate per-class budgets |
| fc_en | input | 1 | Enables the receive flow-control request |
| rx_vld | input | 1 | Receive byte strobe |
| rx_hi | input | 1 | Receive strobe belongs to the high class |
| rx_bytes | input | BW | Bytes reported by this receive strobe |
| rx_last | input | 1 | Receive strobe ends its packet |
| tx_vld | input | 1 | Transmit byte strobe |
| tx_hi | input | 1 | Transmit strobe belongs to the high class |
| tx_bytes | input | BW | Bytes reported by this transmit strobe |
| tx_last | input | 1 | Transmit strobe ends its packet |
| rx_lim_lo | input | CW | Receive low-class limit, bytes per window, 0 = unlimited |
| rx_lim_hi | input | CW | Receive high-class limit |
| tx_lim_lo | input | CW | Transmit low-class limit |
| tx_lim_hi | input | CW | Transmit high-class limit |
| rx_block | output | 2 | Receive block flags, bit 1 high class, bit 0 low class |
| tx_block | output | 2 | Transmit block flags, same bit order |
| rx_fc | output | 1 | Receive flow-control request |

## Verification
Each budget carries properties that are checked on every cycle. A block bit stays set until a tick and clears after a tick with no strobe. A block bit never rises inside a packet. A saturated count stays saturated. A zero limit never produces a block. A low `fc_en` forces the request low. The margin selection at the 15999/16000 boundary, the strictly-greater comparison, class routing under `prio_en`, and saturation shown through a block at limit 65534 can only be shown by the bench's scenarios. Those scenarios run against a reference model inside the bench.

// File: rtl/rl_pkg.sv
package rl_pkg;
    localparam int NDIR   = 2;
    localparam int NCLS   = 2;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;
    localparam int CLS_LO = 0;
    localparam int CLS_HI = 1;
endpackage

// File: rtl/rl_budget.sv
module rl_budget #(
    parameter int CW        = 32,
    parameter int BW        = 12,
    parameter bit HAS_FC    = 1'b1,
    parameter int THR       = 16000,
    parameter int MARGIN_HI = 8192,
    parameter int MARGIN_LO = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          vld,
    input  logic [BW-1:0] nbytes,
    input  logic          last,
    input  logic [CW-1:0] limit,
    input  logic          fc_en,
    output logic          block,
    output logic          fc
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW:0]   M_HI = (CW+1)'(MARGIN_HI);
    localparam logic [CW:0]   M_LO = (CW+1)'(MARGIN_LO);
    localparam logic [CW-1:0] THR_V = CW'(THR);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          in_pkt;
        logic          blk;
        logic          fc;
    } st_t;

    st_t st_d, st_q;
    logic [CW:0]   sum_d, margin_d, reach_d;
    logic [CW-1:0] base_d;
    logic          over_d, near_d;

    always_comb begin
        st_d     = st_q;
        base_d   = tick ? '0 : st_q.cnt;
        sum_d    = {1'b0, base_d} + (vld ? (CW+1)'(nbytes) : '0);
        st_d.cnt = sum_d[CW] ? CMAX : sum_d[CW-1:0];
        if (vld) st_d.in_pkt = !last;
        over_d   = (limit != '0) && (st_d.cnt > limit);
        st_d.blk = (st_q.blk && !tick) || (over_d && !st_d.in_pkt);
        margin_d = (limit >= THR_V) ? M_HI : M_LO;
        reach_d  = {1'b0, st_d.cnt} + margin_d;
        near_d   = (limit != '0) && (reach_d >= {1'b0, limit});
        st_d.fc  = HAS_FC && fc_en && ((st_q.fc && !tick) || near_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign block = st_q.blk;
    assign fc    = st_q.fc;

    assert_block_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (block && !tick) |=> block);
    assert_no_mid_pkt_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block) |-> !st_q.in_pkt);
    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CMAX && !tick) |=> st_q.cnt == CMAX);
    assert_zero_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0 && !block) |=> !block);
    assert_fc_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !fc);
    assert_tick_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !vld) |=> !block);
endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter
    import rl_pkg::*;
#(
    parameter int CW        = 32,
    parameter int BW        = 12,
    parameter int THR       = 16000,
    parameter int MARGIN_HI = 8192,
    parameter int MARGIN_LO = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_tick,
    input  logic          prio_en,
    input  logic          fc_en,
    input  logic          rx_vld,
    input  logic          rx_hi,
    input  logic [BW-1:0] rx_bytes,
    input  logic          rx_last,
    input  logic          tx_vld,
    input  logic          tx_hi,
    input  logic [BW-1:0] tx_bytes,
    input  logic          tx_last,
    input  logic [CW-1:0] rx_lim_lo,
    input  logic [CW-1:0] rx_lim_hi,
    input  logic [CW-1:0] tx_lim_lo,
    input  logic [CW-1:0] tx_lim_hi,
    output logic [1:0]    rx_block,
    output logic [1:0]    tx_block,
    output logic          rx_fc
);
    logic          dir_vld   [NDIR];
    logic          dir_hi    [NDIR];
    logic [BW-1:0] dir_bytes [NDIR];
    logic          dir_last  [NDIR];
    logic [CW-1:0] lim       [NDIR][NCLS];
    logic          blk_w     [NDIR][NCLS];
    logic          fc_w      [NDIR][NCLS];

    always_comb begin
        dir_vld[DIR_RX]   = rx_vld;    dir_vld[DIR_TX]   = tx_vld;
        dir_hi[DIR_RX]    = rx_hi;     dir_hi[DIR_TX]    = tx_hi;
        dir_bytes[DIR_RX] = rx_bytes;  dir_bytes[DIR_TX] = tx_bytes;
        dir_last[DIR_RX]  = rx_last;   dir_last[DIR_TX]  = tx_last;
        lim[DIR_RX][CLS_LO] = rx_lim_lo;
        lim[DIR_RX][CLS_HI] = rx_lim_hi;
        lim[DIR_TX][CLS_LO] = tx_lim_lo;
        lim[DIR_TX][CLS_HI] = tx_lim_hi;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic to_hi;
        assign to_hi = prio_en && dir_hi[d];
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            logic sel;
            assign sel = dir_vld[d] && ((c == CLS_HI) ? to_hi : !to_hi);
            rl_budget #(
                .CW(CW), .BW(BW), .HAS_FC(d == DIR_RX), .THR(THR),
                .MARGIN_HI(MARGIN_HI), .MARGIN_LO(MARGIN_LO)
            ) u_bud (
                .clk(clk), .rst_n(rst_n), .tick(win_tick),
                .vld(sel), .nbytes(dir_bytes[d]), .last(dir_last[d]),
                .limit(lim[d][c]), .fc_en(fc_en),
                .block(blk_w[d][c]), .fc(fc_w[d][c])
            );
        end
    end

    // Without priority only the low budget counts, so it drives both bits.
    assign rx_block = prio_en ? {blk_w[DIR_RX][CLS_HI], blk_w[DIR_RX][CLS_LO]}
                              : {2{blk_w[DIR_RX][CLS_LO]}};
    assign tx_block = prio_en ? {blk_w[DIR_TX][CLS_HI], blk_w[DIR_TX][CLS_LO]}
                              : {2{blk_w[DIR_TX][CLS_LO]}};
    // Transmit budgets are built without flow control and hold their fc at zero.
    assign rx_fc = fc_w[DIR_RX][CLS_LO] | fc_w[DIR_RX][CLS_HI]
                 | fc_w[DIR_TX][CLS_LO] | fc_w[DIR_TX][CLS_HI];
endmodule

// File: tb/sim_port_rate_limiter.sv
module sim_port_rate_limiter;
    localparam int CW = 16;
    localparam int BW = 12;
    localparam int CMAX = 65535;

    logic clk = 1'b0, rst_n = 1'b0;
    logic win_tick = 0, prio_en = 0, fc_en = 0;
    logic rx_vld = 0, rx_hi = 0, rx_last = 0, tx_vld = 0, tx_hi = 0, tx_last = 0;
    logic [BW-1:0] rx_bytes = '0, tx_bytes = '0;
    logic [CW-1:0] rx_lim_lo = '0, rx_lim_hi = '0, tx_lim_lo = '0, tx_lim_hi = '0;
    logic [1:0] rx_block, tx_block;
    logic rx_fc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_cnt [2][2];
    bit m_in [2][2], m_blk [2][2], m_fc [2][2];

    always #2.5 clk = ~clk;

    port_rate_limiter #(.CW(CW), .BW(BW)) u0 (.*);

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int margin_of(input int lim);
        return (lim >= 16000) ? 8192 : 2048;
    endfunction

    function automatic int lim_of(input int d, input int c);
        if (d == 0) return (c == 1) ? int'(rx_lim_hi) : int'(rx_lim_lo);
        return (c == 1) ? int'(tx_lim_hi) : int'(tx_lim_lo);
    endfunction

    task automatic model_update();
        for (int d = 0; d < 2; d++) begin
            bit v = (d == 0) ? rx_vld : tx_vld;
            bit h = (d == 0) ? rx_hi : tx_hi;
            bit l = (d == 0) ? rx_last : tx_last;
            int b = (d == 0) ? int'(rx_bytes) : int'(tx_bytes);
            int tc = (prio_en && h) ? 1 : 0;
            for (int c = 0; c < 2; c++) begin
                bit mine = v && (c == tc);
                int lim = lim_of(d, c);
                int s = (win_tick ? 0 : m_cnt[d][c]) + (mine ? b : 0);
                bit over, near;
                if (s > CMAX) s = CMAX;
                m_cnt[d][c] = s;
                if (mine) m_in[d][c] = !l;
                over = (lim != 0) && (s > lim);
                near = (lim != 0) && (s + margin_of(lim) >= lim);
                m_blk[d][c] = (m_blk[d][c] && !win_tick) || (over && !m_in[d][c]);
                m_fc[d][c] = (d == 0) && fc_en && ((m_fc[d][c] && !win_tick) || near);
            end
        end
    endtask

    function automatic int exp_blk(input int d);
        return prio_en ? {m_blk[d][1], m_blk[d][0]} : {m_blk[d][0], m_blk[d][0]};
    endfunction

    task automatic compare_all();
        chk(rx_block, exp_blk(0), "R3 rx_block vs model");
        chk(tx_block, exp_blk(1), "R5 tx_block vs model");
        chk(rx_fc, m_fc[0][0] | m_fc[0][1], "R7/R8 rx_fc vs model");
    endtask

    task automatic step(input bit rv, input bit rh, input int rb, input bit rl,
                        input bit tv, input bit th, input int tb, input bit tl,
                        input bit tk);
        @(negedge clk);
        rx_vld = rv; rx_hi = rh; rx_bytes = BW'(rb); rx_last = rl;
        tx_vld = tv; tx_hi = th; tx_bytes = BW'(tb); tx_last = tl;
        win_tick = tk;
        model_update();
        @(posedge clk); #1;
        compare_all();
    endtask

    task automatic rx(input int b, input bit l, input bit h = 0);
        step(1, h, b, l, 0, 0, 0, 0, 0);
    endtask
    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic tick(); step(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk(rx_block, 0, "R3 reset rx_block");
        chk(tx_block, 0, "R5 reset tx_block");
        chk(rx_fc, 0, "R10 reset rx_fc");
        @(negedge clk); rst_n = 1;

        // R4 then R3: crossing inside a packet waits for its end
        rx_lim_lo = 1000;
        rx(600, 0); rx(600, 0);
        chk(rx_block, 0, "R4 no block mid packet");
        rx(10, 1);
        chk(rx_block, 3, "R3 block after packet end");
        idle(); idle();
        chk(rx_block, 3, "R3 block held in window");
        tick();
        chk(rx_block, 0, "R12 tick clears block");

        // R1: strict greater, accumulation across packets, restart at tick
        rx_lim_lo = 3000;
        rx(1000, 1); rx(1000, 1); rx(1000, 1);
        chk(rx_block, 0, "R1 count equal to limit not blocked");
        rx(1, 1);
        chk(rx_block, 3, "R1 one byte over limit blocks");
        step(1, 0, 2900, 1, 0, 0, 0, 0, 1);
        chk(rx_block, 0, "R1 restart at tick with strobe");
        rx(200, 1);
        chk(rx_block, 3, "R1 new window counts tick-cycle bytes");
        tick();

        // R7 / R8 / R10 margin selection
        fc_en = 1; rx_lim_lo = 20000;
        rx(4000, 0); rx(4000, 0); rx(3000, 1);
        chk(rx_fc, 0, "R7 below 8192 margin");
        rx(900, 1);
        chk(rx_fc, 1, "R7 within 8192 margin");
        idle();
        chk(rx_fc, 1, "R10 fc held");
        tick();
        chk(rx_fc, 0, "R10 fc cleared by tick");
        rx_lim_lo = 15999;
        rx(4000, 0); rx(4000, 0); rx(4000, 0); rx(1000, 1);
        chk(rx_fc, 0, "R8 limit 15999 uses 2048 margin");
        rx(1000, 1);
        chk(rx_fc, 1, "R8 within 2048 margin");
        tick();
        rx_lim_lo = 16000;
        rx(4000, 0); rx(4000, 0); rx(4000, 0); rx(1000, 1);
        chk(rx_fc, 1, "R7 limit 16000 uses 8192 margin");
        fc_en = 0;
        idle();
        chk(rx_fc, 0, "R9 fc disabled");
        tick();

        // R6: zero limit
        fc_en = 1; rx_lim_lo = 0;
        for (int i = 0; i < 15; i++) rx(4000, i == 14);
        chk(rx_block, 0, "R6 zero limit never blocks");
        chk(rx_fc, 0, "R6 zero limit no fc");
        tick(); fc_en = 0;

        // R2: saturation shows as a block at limit 65534
        rx_lim_lo = 65534;
        for (int i = 0; i < 16; i++) rx(4095, 0);
        rx(100, 1);
        chk(rx_block, 3, "R2 saturated count exceeds 65534");
        tick();

        // R11: per-class budgets
        prio_en = 1; rx_lim_lo = 1000; rx_lim_hi = 5000;
        rx(2000, 1, 1);
        chk(rx_block, 0, "R11 high packet under high limit");
        rx(1500, 1, 0);
        chk(rx_block, 1, "R11 low class blocks alone");
        rx(4000, 1, 1);
        chk(rx_block, 3, "R11 high class blocks");
        tick(); prio_en = 0;
        rx(1500, 1, 1);
        chk(rx_block, 3, "R11 prio off routes to low budget");
        tick();

        // R5: transmit
        tx_lim_lo = 500;
        step(0, 0, 0, 0, 1, 0, 300, 0, 0);
        step(0, 0, 0, 0, 1, 0, 300, 0, 0);
        chk(tx_block, 0, "R5 tx no block mid packet");
        step(0, 0, 0, 0, 1, 0, 1, 1, 0);
        chk(tx_block, 3, "R5 tx block after packet");
        chk(rx_block, 0, "R5 rx untouched by tx");
        tick();

        // constrained random phase against the model
        for (int it = 0; it < 6000; it++) begin
            if (it % 500 == 0) begin
                int pick [6] = '{0, 1200, 15999, 16000, 20000, 40000};
                rx_lim_lo = CW'(pick[$urandom_range(0, 5)]);
                rx_lim_hi = CW'(pick[$urandom_range(0, 5)]);
                tx_lim_lo = CW'(pick[$urandom_range(0, 5)]);
                tx_lim_hi = CW'($urandom_range(0, 65535));
                prio_en = 1'($urandom_range(0, 1));
                fc_en = 1'($urandom_range(0, 3) != 0);
            end
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 1600), $urandom_range(0, 9) < 3,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 1600), $urandom_range(0, 9) < 3,
                 $urandom_range(0, 199) == 0);
        end
        done = 1;
        summary();
    end
endmodule